// File: doc/BRIEF.md
# Power-Stage Gate-Enable Safety Interlock

This block is the last gate between the controller and the heater power switch. It owns the single gate-enable line. It raises that line only when the supply rail is valid, the watchdog is being serviced, no hardware protection input is active, the flow key is present and firmware is asking for heat. When any protection source fires, the gate drops in the same cycle. The block then falls into an inhibited state that only an explicit and qualified re-arm can leave.

The inhibited state and its fault flags are separate from the controller's own reset. A controller reset pulse forces the gate off and is recorded, but it does not clear anything. The overcurrent comparator can be masked for a fixed number of cycles after each switching edge, so that turn-on artifacts are not taken as faults. Once the gate is off, the block records which source tripped first, the commanded power level, the two trust bits and a free-running timestamp. This snapshot is published one cycle after the inhibit latches. A small classifier reports whether the most recent cause of a reset was a brownout, a watchdog expiry or an external request.

Top module: `pwr_gate_guard`

## Requirements
- R1: `gate_en_o` is high only when the block is armed, `rail_ok_i`, `flow_key_i` and `fw_en_i` are all high, and no trip source is active in the same cycle. Dropping `fw_en_i` or `flow_key_i` turns the gate off without latching a fault.
- R2: A low `rail_ok_i`, an expired watchdog or a high `ctrl_rst_i` drives `gate_en_o` low in the same cycle, whatever `fw_en_i` is.
- R3: Any active trip source clears the armed state at the next edge, so `inhibit_o` becomes 1. The inhibit then stays set until a valid re-arm. A `ctrl_rst_i` pulse never clears it.
- R4: A re-arm request (`rearm_i`) is honoured only when all of these hold: `rail_ok_i` has been high for at least `qual_time_i` consecutive edges, `sens_trust_i` is high, `oc_trip_i` is low and no trip source is active. Otherwise the request is ignored.
- R5: `trip_flags_o` is a sticky register. Bit 0 is leakage, bit 1 over-temperature, bit 2 unblanked overcurrent, bit 3 undervoltage, bit 4 watchdog and bit 5 controller reset. Each bit sets while its source is active and clears only on a valid re-arm.
- R6: Overcurrent is ignored in the cycle of a `sw_edge_i` pulse and in the next `BLANK_CYC-1` cycles (4 cycles in total with the defaults). In the cycle after that, it trips again.
- R7: `first_src_o` holds the first trip since the last re-arm, encoded as 0 none, 1 leakage, 2 over-temperature, 3 overcurrent, 4 undervoltage, 5 watchdog, 6 controller reset. When several sources fire together, the lowest code wins.
- R8: `snap_valid_o` rises one cycle after `inhibit_o` has latched for the first trip. The snapshot holds `pwr_lvl_i`, the pair {`flow_key_i`, `sens_trust_i`} (flow in bit 1) and the timestamp, all taken from the trip cycle. A valid re-arm clears `snap_valid_o`.
- R9: `rst_cause_o` keeps the most recent reset cause, encoded as 0 none, 1 brownout, 2 watchdog, 3 external. When causes coincide, brownout takes priority over watchdog, and watchdog over external.
- R10: The watchdog is reloaded to `WDG_TO` by `wdg_kick_i`. If `WDG_TO` edges pass without a kick, it expires and trips. A later kick restores it.
- R11: After the block's own reset, the gate is off, `inhibit_o` is 1, the flags, first source, cause and `snap_valid_o` are all 0, and a re-arm is needed before any heating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset (power-on only) |
| rail_ok_i | input | 1 | Control rail above undervoltage threshold |
| wdg_kick_i | input | 1 | Watchdog service pulse |
| rcd_trip_i | input | 1 | Leakage comparator output |
| otp_trip_i | input | 1 | Hardware over-temperature cutoff |
| oc_trip_i | input | 1 | Overcurrent / desaturation comparator |
| sw_edge_i | input | 1 | Switching-edge marker, starts the blanking window |
| flow_key_i | input | 1 | Flow plausibility key |
| sens_trust_i | input | 1 | Sensors trusted |
| fw_en_i | input | 1 | Firmware heat request |
| ctrl_rst_i | input | 1 | Imminent or active controller reset |
| rearm_i | input | 1 | Re-arm request |
| qual_time_i | input | QW | Rail qualify time in cycles |
| pwr_lvl_i | input | PW | Commanded power level |
| gate_en_o | output | 1 | Final gate enable |
| inhibit_o | output | 1 | Latched inhibit |
| trip_flags_o | output | 6 | Sticky trip flags |
| first_src_o | output | 3 | First trip source code |
| rst_cause_o | output | 2 | Reset cause code |
| snap_valid_o | output | 1 | Snapshot valid |
| snap_pwr_o | output | PW | Power level at trip |
| snap_trust_o | output | 2 | {flow key, sensor trust} at trip |
| snap_ts_o | output | TS_W | Timestamp at trip |

## Verification
A stuck or lost armed bit shows up at once as a gate that ignores its conditions, or as an `inhibit_o` that drops without a qualified re-arm. The reference model flags either one in the cycle it happens. A miscounted rail-qualify, watchdog or blanking counter moves the cycle in which a re-arm takes effect, the watchdog trips or an overcurrent is honoured. That error becomes visible at the first edge where the counter should have crossed its bound. Errors in the capture order or in the priority encoder show up one to two cycles after the trip, in `first_src_o` and in the snapshot fields.

// File: rtl/gsv_pkg.sv
package gsv_pkg;
  localparam int NSRC = 6;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_RCD  = 3'd1,
    SRC_OTP  = 3'd2,
    SRC_OC   = 3'd3,
    SRC_UV   = 3'd4,
    SRC_WDG  = 3'd5,
    SRC_EXT  = 3'd6
  } src_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_BROWN = 2'd1,
    CAUSE_WDG   = 2'd2,
    CAUSE_EXT   = 2'd3
  } cause_e;

  // lowest index wins
  function automatic src_e first_of(input logic [NSRC-1:0] v);
    src_e r;
    r = SRC_NONE;
    for (int i = NSRC-1; i >= 0; i--) begin
      if (v[i]) r = src_e'(3'(i+1));
    end
    return r;
  endfunction
endpackage

// File: rtl/gsv_rail_qual.sv
module gsv_rail_qual #(
  parameter int QW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rail_ok_i,
  input  logic [QW-1:0] qual_time_i,
  output logic          qual_o
);
  logic [QW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!rail_ok_i)     cnt_q <= '0;
    else if (cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o = rail_ok_i && (cnt_q >= qual_time_i);

  // any low rail sample restarts qualification
  p_rail_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rail_ok_i |=> cnt_q == '0);
endmodule

// File: rtl/gsv_wdog.sv
module gsv_wdog #(
  parameter int WDG_TO = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic ok_o
);
  localparam int WW = $clog2(WDG_TO + 1);
  localparam logic [WW-1:0] RELOAD = WW'(WDG_TO);

  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= RELOAD;
    else if (kick_i)      cnt_q <= RELOAD;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign ok_o = (cnt_q != '0);

  p_kick_reload_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> ok_o && cnt_q == RELOAD);
  p_count_down_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!kick_i && cnt_q > 1) |=> ok_o);
endmodule

// File: rtl/gsv_blank.sv
module gsv_blank #(
  parameter int BLANK_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  output logic active_o
);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam logic [BW-1:0] LOAD = BW'(BLANK_CYC - 1);

  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (edge_i)      cnt_q <= LOAD;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = edge_i || (cnt_q != '0);

  // window never stretches without a new edge
  p_blank_shrink_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  p_blank_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD);
endmodule

// File: rtl/gsv_trip_latch.sv
module gsv_trip_latch import gsv_pkg::*; #(
  parameter int PW   = 8,
  parameter int TS_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic            oc_raw_i,
  input  logic            rearm_i,
  input  logic            qual_i,
  input  logic            trust_i,
  input  logic [1:0]      trust_snap_i,
  input  logic [PW-1:0]   pwr_i,
  input  logic [TS_W-1:0] ts_i,
  output logic            armed_o,
  output logic [NSRC-1:0] flags_o,
  output src_e            first_o,
  output logic            snap_valid_o,
  output logic [PW-1:0]   snap_pwr_o,
  output logic [1:0]      snap_trust_o,
  output logic [TS_W-1:0] snap_ts_o
);
  logic armed_q, pend_q, valid_q, any_trip, can_rearm, capture;
  logic [NSRC-1:0] flags_q;
  src_e first_q;

  assign any_trip  = |src_i;
  assign can_rearm = rearm_i && !armed_q && qual_i && trust_i && !any_trip && !oc_raw_i;
  assign capture   = any_trip && (flags_q == '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flags_q[g] <= 1'b0;
      else if (can_rearm) flags_q[g] <= 1'b0;
      else if (src_i[g])  flags_q[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        armed_q <= 1'b0;
    else if (any_trip)  armed_q <= 1'b0;
    else if (can_rearm) armed_q <= 1'b1;
  end

  // snapshot published one cycle after the inhibit has latched
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q      <= SRC_NONE;
      pend_q       <= 1'b0;
      valid_q      <= 1'b0;
      snap_pwr_o   <= '0;
      snap_trust_o <= '0;
      snap_ts_o    <= '0;
    end else if (capture) begin
      first_q      <= first_of(src_i);
      pend_q       <= 1'b1;
      snap_pwr_o   <= pwr_i;
      snap_trust_o <= trust_snap_i;
      snap_ts_o    <= ts_i;
    end else if (can_rearm) begin
      first_q <= SRC_NONE;
      pend_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (pend_q) begin
      pend_q  <= 1'b0;
      valid_q <= 1'b1;
    end
  end

  assign armed_o      = armed_q;
  assign flags_o      = flags_q;
  assign first_o      = first_q;
  assign snap_valid_o = valid_q;

  p_trip_latch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_trip |=> !armed_q);
  p_rearm_qual_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(qual_i && trust_i && !oc_raw_i));
  p_leak_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q[0] && !can_rearm) |=> flags_q[0]);
  p_first_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_q != SRC_NONE && !can_rearm) |=> $stable(first_q));
  p_snap_after_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $past(!armed_q) && !armed_q);
endmodule

// File: rtl/pwr_gate_guard.sv
module pwr_gate_guard import gsv_pkg::*; #(
  parameter int QW        = 8,
  parameter int PW        = 8,
  parameter int TS_W      = 16,
  parameter int WDG_TO    = 64,
  parameter int BLANK_CYC = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rail_ok_i,
  input  logic            wdg_kick_i,
  input  logic            rcd_trip_i,
  input  logic            otp_trip_i,
  input  logic            oc_trip_i,
  input  logic            sw_edge_i,
  input  logic            flow_key_i,
  input  logic            sens_trust_i,
  input  logic            fw_en_i,
  input  logic            ctrl_rst_i,
  input  logic            rearm_i,
  input  logic [QW-1:0]   qual_time_i,
  input  logic [PW-1:0]   pwr_lvl_i,
  output logic            gate_en_o,
  output logic            inhibit_o,
  output logic [5:0]      trip_flags_o,
  output logic [2:0]      first_src_o,
  output logic [1:0]      rst_cause_o,
  output logic            snap_valid_o,
  output logic [PW-1:0]   snap_pwr_o,
  output logic [1:0]      snap_trust_o,
  output logic [TS_W-1:0] snap_ts_o
);
  logic rail_qual, wdg_ok, blank_act, armed;
  logic [NSRC-1:0] src;
  logic [NSRC-1:0] flags;
  logic [TS_W-1:0] ts_q;
  src_e first;
  cause_e cause_q;

  gsv_rail_qual #(.QW(QW)) u_qual (
    .clk_i(clk_i), .rst_ni(rst_ni), .rail_ok_i(rail_ok_i),
    .qual_time_i(qual_time_i), .qual_o(rail_qual));

  gsv_wdog #(.WDG_TO(WDG_TO)) u_wdog (
    .clk_i(clk_i), .rst_ni(rst_ni), .kick_i(wdg_kick_i), .ok_o(wdg_ok));

  gsv_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk_i(clk_i), .rst_ni(rst_ni), .edge_i(sw_edge_i), .active_o(blank_act));

  // bit order is the first-fault priority
  assign src = {ctrl_rst_i, ~wdg_ok, ~rail_ok_i, oc_trip_i & ~blank_act,
                otp_trip_i, rcd_trip_i};

  gsv_trip_latch #(.PW(PW), .TS_W(TS_W)) u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src), .oc_raw_i(oc_trip_i),
    .rearm_i(rearm_i), .qual_i(rail_qual), .trust_i(sens_trust_i),
    .trust_snap_i({flow_key_i, sens_trust_i}), .pwr_i(pwr_lvl_i), .ts_i(ts_q),
    .armed_o(armed), .flags_o(flags), .first_o(first),
    .snap_valid_o(snap_valid_o), .snap_pwr_o(snap_pwr_o),
    .snap_trust_o(snap_trust_o), .snap_ts_o(snap_ts_o));

  // direct path: no register between a trip and the gate
  assign gate_en_o = armed && !(|src) && flow_key_i && fw_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ts_q <= '0;
    else         ts_q <= ts_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cause_q <= CAUSE_NONE;
    else if (!rail_ok_i) cause_q <= CAUSE_BROWN;
    else if (!wdg_ok)    cause_q <= CAUSE_WDG;
    else if (ctrl_rst_i) cause_q <= CAUSE_EXT;
  end

  assign inhibit_o    = ~armed;
  assign trip_flags_o = flags;
  assign first_src_o  = first;
  assign rst_cause_o  = cause_q;

  p_gate_cond_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_en_o |-> rail_ok_i && fw_en_i && flow_key_i && !rcd_trip_i && !otp_trip_i);
  p_gate_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rail_ok_i || ctrl_rst_i) |-> !gate_en_o);
  p_rst_keeps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rst_i |=> inhibit_o);
  p_brown_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rail_ok_i |=> rst_cause_o == CAUSE_BROWN);
endmodule

// File: tb/pwr_gate_guard_tb.sv
`timescale 1ns/1ps
module pwr_gate_guard_tb;
  localparam int QW = 8, PW = 8, TS_W = 16, WDG_TO = 64, BLANK_CYC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rail_ok = 0, kick = 0, rcd = 0, otp = 0, oc = 0, sw_edge = 0;
  logic flow = 0, trust = 0, fw_en = 0, crst = 0, rearm = 0;
  logic [QW-1:0] qual_time = 8'd8;
  logic [PW-1:0] pwr = 8'h5A;
  logic gate_en, inhibit, snap_valid;
  logic [5:0] flags;
  logic [2:0] first_src;
  logic [1:0] cause, snap_trust;
  logic [PW-1:0] snap_pwr;
  logic [TS_W-1:0] snap_ts;

  int n_chk = 0, n_bad = 0;
  bit kick_en = 0, done = 0;
  int kph = 0;

  always #2.5 clk = ~clk;

  pwr_gate_guard #(.QW(QW), .PW(PW), .TS_W(TS_W), .WDG_TO(WDG_TO), .BLANK_CYC(BLANK_CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rail_ok_i(rail_ok), .wdg_kick_i(kick),
    .rcd_trip_i(rcd), .otp_trip_i(otp), .oc_trip_i(oc), .sw_edge_i(sw_edge),
    .flow_key_i(flow), .sens_trust_i(trust), .fw_en_i(fw_en), .ctrl_rst_i(crst),
    .rearm_i(rearm), .qual_time_i(qual_time), .pwr_lvl_i(pwr),
    .gate_en_o(gate_en), .inhibit_o(inhibit), .trip_flags_o(flags),
    .first_src_o(first_src), .rst_cause_o(cause), .snap_valid_o(snap_valid),
    .snap_pwr_o(snap_pwr), .snap_trust_o(snap_trust), .snap_ts_o(snap_ts));

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int m_q, m_w, m_b, m_first, m_pwr, m_tsh, m_trh, m_ts, m_cause;
  bit m_armed, m_pend, m_valid;
  bit [5:0] m_flags;

  function automatic bit [5:0] m_src();
    bit [5:0] s;
    s[0] = rcd;
    s[1] = otp;
    s[2] = oc && !(sw_edge || m_b != 0);
    s[3] = !rail_ok;
    s[4] = (m_w == 0);
    s[5] = crst;
    return s;
  endfunction

  function automatic int m_enc(bit [5:0] s);
    for (int i = 0; i < 6; i++) if (s[i]) return i + 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q = 0; m_w = WDG_TO; m_b = 0; m_first = 0; m_pwr = 0; m_tsh = 0;
      m_trh = 0; m_ts = 0; m_cause = 0; m_armed = 0; m_pend = 0; m_valid = 0;
      m_flags = 0;
    end else begin
      bit [5:0] s;
      bit anyt, cr, qual;
      s = m_src();
      anyt = (s != 0);
      qual = rail_ok && (m_q >= int'(qual_time));
      cr = rearm && !m_armed && qual && trust && !anyt && !oc;
      if (anyt && m_flags == 0) begin
        m_first = m_enc(s); m_pwr = pwr; m_tsh = m_ts; m_trh = {flow, trust}; m_pend = 1;
      end else if (cr) begin
        m_first = 0; m_pend = 0; m_valid = 0;
      end else if (m_pend) begin
        m_pend = 0; m_valid = 1;
      end
      m_flags = cr ? 6'd0 : (m_flags | s);
      if (anyt) m_armed = 0; else if (cr) m_armed = 1;
      if (!rail_ok) m_cause = 1; else if (m_w == 0) m_cause = 2; else if (crst) m_cause = 3;
      if (!rail_ok) m_q = 0; else if (m_q < 255) m_q++;
      if (kick) m_w = WDG_TO; else if (m_w > 0) m_w--;
      if (sw_edge) m_b = BLANK_CYC - 1; else if (m_b > 0) m_b--;
      m_ts = (m_ts + 1) & 16'hFFFF;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 gate_en model", gate_en, (m_armed && m_src() == 0 && flow && fw_en) ? 1 : 0);
      chk("R3 inhibit model", inhibit, m_armed ? 0 : 1);
      chk("R5 flags model", flags, m_flags);
      chk("R7 first_src model", first_src, m_first);
      chk("R8 snap_valid model", snap_valid, m_valid);
      chk("R9 cause model", cause, m_cause);
      if (m_valid) begin
        chk("R8 snap_pwr model", snap_pwr, m_pwr);
        chk("R8 snap_trust model", snap_trust, m_trh);
        chk("R8 snap_ts model", snap_ts, m_tsh);
      end
    end
  end

  // watchdog service generator
  initial forever begin
    @(posedge clk); #1;
    kick = kick_en && (kph == 0);
    kph = (kph + 1) % 16;
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_rearm();
    rearm = 1; cyc(1); rearm = 0;
  endtask

  initial begin
    cyc(3);
    @(negedge clk);
    // R11 reset state
    chk("R11 gate off", gate_en, 0);
    chk("R11 inhibit", inhibit, 1);
    chk("R11 flags", flags, 0);
    chk("R11 first", first_src, 0);
    chk("R11 snap_valid", snap_valid, 0);
    chk("R11 cause", cause, 0);
    cyc(1);
    rst_n = 1; kick_en = 1;
    cyc(2);
    rail_ok = 1; trust = 1; flow = 1; fw_en = 1;
    cyc(3);
    pulse_rearm();
    @(negedge clk);
    chk("R4 early rearm ignored", inhibit, 1);
    chk("R11 no heat before rearm", gate_en, 0);
    cyc(10);
    pulse_rearm();
    @(negedge clk);
    chk("R4 qualified rearm", inhibit, 0);
    chk("R1 gate on", gate_en, 1);
    cyc(1); fw_en = 0;
    @(negedge clk);
    chk("R1 fw_en low gate off", gate_en, 0);
    cyc(1);
    chk("R1 no latch on fw_en", inhibit, 0);
    fw_en = 1;
    // leakage trip
    cyc(1); rcd = 1; pwr = 8'h33;
    @(negedge clk);
    chk("R2 leak gate off", gate_en, 0);
    cyc(1); rcd = 0;
    @(negedge clk);
    chk("R5 leak flag", flags, 6'h01);
    chk("R7 first leak", first_src, 1);
    chk("R3 inhibit latched", inhibit, 1);
    cyc(1);
    @(negedge clk);
    chk("R8 snap valid", snap_valid, 1);
    chk("R8 snap pwr", snap_pwr, 8'h33);
    chk("R8 snap trust", snap_trust, 3);
    crst = 1;
    @(negedge clk);
    chk("R2 reset gate off", gate_en, 0);
    cyc(1); crst = 0;
    @(negedge clk);
    chk("R3 reset keeps inhibit", inhibit, 1);
    chk("R9 cause ext", cause, 3);
    chk("R5 flags sticky", flags, 6'h21);
    trust = 0;
    pulse_rearm();
    @(negedge clk);
    chk("R4 untrusted rearm ignored", inhibit, 1);
    trust = 1;
    pulse_rearm();
    @(negedge clk);
    chk("R4 rearm ok", inhibit, 0);
    chk("R5 flags cleared", flags, 0);
    chk("R8 snap cleared", snap_valid, 0);
    // blanking
    cyc(2); sw_edge = 1; oc = 1;
    for (int i = 0; i < BLANK_CYC; i++) begin
      @(negedge clk);
      chk("R6 oc blanked", gate_en, 1);
      cyc(1); sw_edge = 0;
    end
    oc = 0; cyc(2);
    sw_edge = 1; cyc(1); sw_edge = 0; cyc(BLANK_CYC - 1);
    oc = 1;
    @(negedge clk);
    chk("R6 oc after window", gate_en, 0);
    cyc(1); oc = 0;
    @(negedge clk);
    chk("R6 oc latched", inhibit, 1);
    chk("R7 first oc", first_src, 3);
    pulse_rearm();
    // simultaneous sources
    cyc(6); otp = 1; oc = 1;
    cyc(1); otp = 0; oc = 0;
    @(negedge clk);
    chk("R7 priority otp", first_src, 2);
    pulse_rearm();
    // brownout with bounce
    cyc(2); rail_ok = 0;
    @(negedge clk);
    chk("R2 brownout gate off", gate_en, 0);
    cyc(1); rail_ok = 1;
    @(negedge clk);
    chk("R9 cause brownout", cause, 1);
    cyc(3); rail_ok = 0; cyc(1); rail_ok = 1;
    cyc(5);
    pulse_rearm();
    @(negedge clk);
    chk("R4 bounce blocks rearm", inhibit, 1);
    cyc(5);
    pulse_rearm();
    @(negedge clk);
    chk("R4 rearm after qualify", inhibit, 0);
    // watchdog expiry
    kick_en = 0;
    cyc(WDG_TO + 6);
    @(negedge clk);
    chk("R10 watchdog gate off", gate_en, 0);
    chk("R9 cause watchdog", cause, 2);
    chk("R10 first watchdog", first_src, 5);
    kick_en = 1;
    cyc(20);
    pulse_rearm();
    @(negedge clk);
    chk("R10 recovered", inhibit, 0);
    // external reset while armed
    cyc(1); crst = 1;
    @(negedge clk);
    chk("R2 ext gate off", gate_en, 0);
    cyc(1); crst = 0;
    @(negedge clk);
    chk("R3 first ext", first_src, 6);
    cyc(3);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog timeout act=0 exp=1");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule